// File: doc/BRIEF.md
# Pseudo-SRAM Access Sequencer

This block sits between a host and an asynchronous 16-bit pseudo-static RAM with a 20-bit word address. The host hands over one word access at a time on a valid/ready request port. Each request carries an address, write data, a two-bit byte-enable and a read/write flag. The block turns each request into a timed sequence on the memory pins: chip-enable, output-enable, write-enable, two active-low byte strobes, the address bus, and a data bus split into out, output-enable and in. Read data comes back on a one-cycle response strobe.

All pin timing comes from cycle counters. Each counter is the ceiling of a nanosecond figure divided by the clock-period parameter, with a floor of one clock. The read window is set by the slowest of three delays: address or chip-enable access (70 ns), output-enable access (40 ns) and byte-strobe access (25 ns). The write window is set by the longest of three figures: 60 ns of chip-enable and strobe assertion, a 40 ns write-enable pulse, and 30 ns of data setup. Chip-enable is always returned high between accesses. The memory hides refresh inside each access, so a chip-enable low period also has an upper bound of 32 us. The block accepts no request while the power manager reports that the memory is not active.

Top module: `psram_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle and `pwr_active` is high. While `pwr_active` is low, a pending request is not taken and chip-enable stays high.
- R2: A read drives chip-enable and output-enable low with write-enable high, for RD cycles. RD is the largest of ceil(70/P), ceil(40/P) and ceil(25/P), which is 4 at P = 20 ns. The data is captured at the end of that window, after every access delay has elapsed. `rsp_valid` is high for exactly one cycle, RD cycles after the accepting edge, with the data on `rsp_rdata`.
- R3: A write holds chip-enable, write-enable and the enabled strobes low for WR cycles. WR is the largest of ceil(60/P), ceil(40/P) and ceil(30/P), which is 3 at P = 20 ns. Write data is driven on the bus for the whole window, and output-enable stays high.
- R4: `req_be` bit 0 maps to `mem_bs_n` bit 0 and data bits 7..0; bit 1 maps to `mem_bs_n` bit 1 and bits 15..8. Strobes are active low. Lanes that are not enabled are left untouched by a write and read back as zero.
- R5: After every access, chip-enable stays high for at least RC cycles. RC is the larger of ceil(30/P) and ceil(70/P) minus the shorter access window, which is 2 at P = 20 ns. `req_ready` returns RD+RC cycles after a read is accepted and WR+RC cycles after a write is accepted. The time from one chip-enable fall to the next is at least 70 ns.
- R6: Chip-enable never stays low longer than 32 us.
- R7: The address is valid when chip-enable falls and does not change while chip-enable is low.
- R8: A write that follows a read first waits TA = ceil(15/P) cycles with the bus released, which adds TA cycles to its ready latency. The data bus is never driven within 15 ns of the memory ending a read.
- R9: After reset, chip-enable, output-enable, write-enable and both strobes are high, the data bus is released, `rsp_valid` is low, and `req_ready` follows `pwr_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_active | input | 1 | Power manager reports memory in active state |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7..0 |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_we_n | output | 1 | Memory write-enable, active low |
| mem_bs_n | output | 2 | Byte strobes, active low, bit 0 = lower lane |
| mem_addr | output | 20 | Memory address |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from memory |

## Verification
A behavioural memory in the bench drives deliberately wrong data until every access delay of a read has elapsed, and it drives filler on unstrobed lanes. A sequencer that samples too early, or that fails to mask unused lanes, therefore returns a visibly wrong word. Directed sequences cover the following cases:
- merged lower and upper byte writes, which separate correct lane steering from whole-word writes;
- an all-disabled write, which must leave the word unchanged;
- the top address;
- a write straight after a read, which separates the turnaround wait from the plain write latency;
- a power-down interval with a request pending.

A seeded random mix of reads and writes over a small address set then checks data against a shadow copy, checks the latencies, and has every cycle-time, pulse-width, setup, address-hold and bus-contention limit measured in nanoseconds.

// File: rtl/psram_seq_pkg.sv
`timescale 1ns/1ps
package psram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_RD    = 3'd2,
    ST_WR    = 3'd3,
    ST_RECOV = 3'd4
  } seq_st_t;

  // nanoseconds to clock cycles, rounded up, never below one clock
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_cnt.sv
`timescale 1ns/1ps
module psram_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (ld)            cnt_q <= ld_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/psram_lanes.sv
`timescale 1ns/1ps
module psram_lanes #(
  parameter int DW    = 16,
  localparam int LANES = DW / 8
) (
  input  logic             active,
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0]    dq_in,
  output logic [LANES-1:0] bs_n,
  output logic [DW-1:0]    rd_word
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign bs_n[i]          = !(active && be[i]);
    assign rd_word[i*8 +: 8] = be[i] ? dq_in[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/psram_seq.sv
`timescale 1ns/1ps
module psram_seq #(
  parameter int CLK_PERIOD_NS = 20,
  parameter int AW            = 20,
  parameter int DW            = 16,
  parameter int T_ACC_NS      = 70,
  parameter int T_OE_ACC_NS   = 40,
  parameter int T_BS_ACC_NS   = 25,
  parameter int T_CYC_MIN_NS  = 70,
  parameter int T_CYC_MAX_NS  = 32000,
  parameter int T_WE_PW_NS    = 40,
  parameter int T_CE_WR_NS    = 60,
  parameter int T_DS_NS       = 30,
  parameter int T_CE_HI_NS    = 30,
  parameter int T_HZ_NS       = 15,
  localparam int LANES        = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_active,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_wr,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_be,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             mem_ce_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [LANES-1:0] mem_bs_n,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_in
);
  import psram_seq_pkg::*;

  localparam int P       = CLK_PERIOD_NS;
  localparam int RD_CYC  = imax(ns2cyc(T_ACC_NS, P), imax(ns2cyc(T_OE_ACC_NS, P), ns2cyc(T_BS_ACC_NS, P)));
  localparam int WR_CYC  = imax(ns2cyc(T_CE_WR_NS, P), imax(ns2cyc(T_WE_PW_NS, P), ns2cyc(T_DS_NS, P)));
  localparam int CYC_MIN = ns2cyc(T_CYC_MIN_NS, P);
  localparam int RC_CYC  = imax(ns2cyc(T_CE_HI_NS, P), CYC_MIN - imin(RD_CYC, WR_CYC));
  localparam int TA_CYC  = ns2cyc(T_HZ_NS, P);
  localparam int MAXC    = imax(imax(RD_CYC, WR_CYC), imax(RC_CYC, TA_CYC));
  localparam int CNT_W   = $clog2(MAXC + 1) + 1;
  localparam int LO_MAX  = T_CYC_MAX_NS / P - RC_CYC;
  localparam int LO_W    = $clog2(LO_MAX + 2);

  seq_st_t          st_q, st_nxt;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             cnt_done;
  logic             accept;
  logic             last_rd_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] be_q;
  logic [DW-1:0]    lane_rd;
  // named events for checking
  logic             rd_done, wr_done, access_on;

  assign accept    = req_valid && req_ready;
  assign access_on = (st_q == ST_RD) || (st_q == ST_WR);
  assign rd_done   = (st_q == ST_RD) && cnt_done;
  assign wr_done   = (st_q == ST_WR) && cnt_done;
  assign req_ready = (st_q == ST_IDLE) && pwr_active;

  always_comb begin
    st_nxt = st_q;
    ld     = 1'b0;
    ld_val = '0;
    case (st_q)
      ST_IDLE: if (accept) begin
        ld = 1'b1;
        if (req_wr && last_rd_q) begin
          st_nxt = ST_TURN;  ld_val = CNT_W'(TA_CYC - 1);
        end else if (req_wr) begin
          st_nxt = ST_WR;    ld_val = CNT_W'(WR_CYC - 1);
        end else begin
          st_nxt = ST_RD;    ld_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_TURN: if (cnt_done) begin
        st_nxt = ST_WR; ld = 1'b1; ld_val = CNT_W'(WR_CYC - 1);
      end
      ST_RD, ST_WR: if (cnt_done) begin
        st_nxt = ST_RECOV; ld = 1'b1; ld_val = CNT_W'(RC_CYC - 1);
      end
      ST_RECOV: if (cnt_done) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  psram_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val), .done(cnt_done)
  );

  psram_lanes #(.DW(DW)) u_lanes (
    .active(access_on), .be(be_q), .dq_in(mem_dq_in),
    .bs_n(mem_bs_n), .rd_word(lane_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      last_rd_q <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st_q      <= st_nxt;
      rsp_valid <= rd_done;
      if (rd_done) begin
        rsp_rdata <= lane_rd;
        last_rd_q <= 1'b1;
      end
      if (wr_done) last_rd_q <= 1'b0;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
    end
  end

  assign mem_ce_n   = !access_on;
  assign mem_oe_n   = !(st_q == ST_RD);
  assign mem_we_n   = !(st_q == ST_WR);
  assign mem_dq_oe  = (st_q == ST_WR);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  // pin history counters, used only by the checks below
  logic [CNT_W-1:0] ce_hi_q, since_rd_q;
  logic [LO_W-1:0]  ce_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_hi_q    <= '1;
      since_rd_q <= '1;
      ce_lo_q    <= '0;
    end else begin
      if (mem_ce_n) begin
        ce_lo_q <= '0;
        if (ce_hi_q != '1) ce_hi_q <= ce_hi_q + 1'b1;
      end else begin
        ce_hi_q <= '0;
        if (ce_lo_q != '1) ce_lo_q <= ce_lo_q + 1'b1;
      end
      if (!mem_oe_n)              since_rd_q <= '0;
      else if (since_rd_q != '1)  since_rd_q <= since_rd_q + 1'b1;
    end
  end

  AST_NO_ACCEPT_PWRDN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !pwr_active) |=> mem_ce_n); // R1
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2
  AST_WR_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n)); // R3
  AST_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (&mem_bs_n)); // R4
  AST_CE_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (ce_hi_q >= CNT_W'(RC_CYC))); // R5
  AST_CE_MAX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ce_lo_q <= LO_W'(LO_MAX)); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R7
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (since_rd_q >= CNT_W'(TA_CYC))); // R8
endmodule

// File: tb/psram_seq_tb_top.sv
`timescale 1ns/1ps
module psram_seq_tb_top;
  localparam int  PER  = 20;
  localparam real HALF = 10.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_active = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_wr = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_bs_n;
  logic [19:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'h5A5A;

  int errors = 0;
  int checks = 0;

  always #(PER/2) clk = ~clk;

  psram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_active(pwr_active),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_bs_n(mem_bs_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected cycle counts, restated from the requirements
  function automatic int cyc(input int ns);
    int c = 1;
    while (c * PER < ns) c++;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    if (a > b) return a;
    return b;
  endfunction
  function automatic int exp_rd(); return mx(cyc(70), mx(cyc(40), cyc(25))); endfunction
  function automatic int exp_wr(); return mx(cyc(60), mx(cyc(40), cyc(30))); endfunction
  function automatic int exp_rc();
    int sh = (exp_rd() < exp_wr()) ? exp_rd() : exp_wr();
    return mx(cyc(30), cyc(70) - sh);
  endfunction
  function automatic int exp_ta(); return cyc(15); endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [1:0] be);
    logic [15:0] r = old;
    if (be[0]) r[7:0]  = nw[7:0];
    if (be[1]) r[15:8] = nw[15:8];
    return r;
  endfunction
  function automatic logic [15:0] mask(input logic [15:0] v, input logic [1:0] be);
    return {be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00};
  endfunction

  // ---------------- behavioural memory with timing checks ----------------
  logic [15:0] mdl [int];
  logic [15:0] shadow [int];

  function automatic logic [15:0] mrd(input int a);
    if (mdl.exists(a)) return mdl[a];
    return 16'h0000;
  endfunction
  function automatic logic [15:0] srd(input int a);
    if (shadow.exists(a)) return shadow[a];
    return 16'h0000;
  endfunction

  real t_ce_fall = 0.0, t_ce_rise = 0.0, t_oe_fall = 0.0, t_rd_end = -100.0;
  real t_wr_start = 0.0, t_dchg = 0.0;
  real t_bs_fall [2];
  bit  have_fall = 0, have_rise = 0;
  logic prev_ce_n = 1, prev_oe_n = 1, prev_dq_oe = 0, prev_rd = 0, prev_wr = 0;
  logic [1:0]  prev_bs = 2'b11, wmask = 2'b00;
  logic [19:0] prev_addr = '0;
  logic [15:0] prev_dout = '0;

  always @(negedge clk) begin
    real et, vt;
    logic rd_c, wr_c;
    logic [15:0] cur, drv;
    et   = $realtime - HALF;
    wr_c = !mem_ce_n && !mem_we_n && (mem_bs_n != 2'b11);
    rd_c = !mem_ce_n && !mem_oe_n && mem_we_n && (mem_bs_n != 2'b11);
    if (rst_n) begin
      if (prev_ce_n && !mem_ce_n) begin
        if (have_rise) chk(et - t_ce_rise >= 30.0, "R5", "CE high ns", longint'(et - t_ce_rise), 30);
        if (have_fall) chk(et - t_ce_fall >= 70.0, "R5", "cycle ns", longint'(et - t_ce_fall), 70);
        t_ce_fall = et; have_fall = 1;
      end
      if (!prev_ce_n && mem_ce_n) begin
        chk(et - t_ce_fall <= 32000.0, "R6", "CE low ns", longint'(et - t_ce_fall), 32000);
        t_ce_rise = et; have_rise = 1;
      end
      if (!prev_ce_n && !mem_ce_n)
        chk(mem_addr == prev_addr, "R7", "address moved under CE", mem_addr, prev_addr);
      if (prev_oe_n && !mem_oe_n) t_oe_fall = et;
      for (int i = 0; i < 2; i++) if (prev_bs[i] && !mem_bs_n[i]) t_bs_fall[i] = et;
      if (prev_rd && !rd_c) t_rd_end = et;
      if (mem_dq_oe && !prev_dq_oe)
        chk(!rd_c && (et - t_rd_end >= 15.0), "R8", "bus driven after read ns",
            longint'(et - t_rd_end), 15);
      if (!mem_we_n) chk(mem_oe_n && mem_dq_oe, "R3", "write pins oe_n/dq_oe",
                         {mem_oe_n, mem_dq_oe}, 2'b11);
      if (wr_c && !prev_wr) begin
        t_wr_start = et; t_dchg = et; wmask = ~mem_bs_n;
      end else if (wr_c && mem_dq_out != prev_dout) begin
        t_dchg = et;
      end
      if (prev_wr && !wr_c) begin
        chk(et - t_wr_start >= 60.0, "R3", "write pulse ns", longint'(et - t_wr_start), 60);
        chk(et - t_dchg >= 30.0, "R3", "data setup ns", longint'(et - t_dchg), 30);
        mdl[int'(prev_addr)] = merge(mrd(int'(prev_addr)), prev_dout, wmask);
      end
      cur = mrd(int'(mem_addr));
      drv = 16'hA5A5;
      for (int i = 0; i < 2; i++) begin
        if (rd_c && !mem_bs_n[i]) begin
          vt = t_ce_fall + 70.0;
          if (t_oe_fall + 40.0 > vt) vt = t_oe_fall + 40.0;
          if (t_bs_fall[i] + 25.0 > vt) vt = t_bs_fall[i] + 25.0;
          drv[i*8 +: 8] = ($realtime + HALF >= vt) ? cur[i*8 +: 8] : ~cur[i*8 +: 8];
        end
      end
      mem_dq_in = drv;
    end
    prev_ce_n = mem_ce_n; prev_oe_n = mem_oe_n; prev_dq_oe = mem_dq_oe;
    prev_rd = rd_c; prev_wr = wr_c; prev_bs = mem_bs_n;
    prev_addr = mem_addr; prev_dout = mem_dq_out;
  end

  // ---------------- host side ----------------
  bit last_was_rd = 0;

  task automatic op(input bit wr, input logic [19:0] addr, input logic [15:0] wd,
                    input logic [1:0] be, output logic [15:0] rd,
                    output int lat_rsp, output int lat_rdy);
    int k;
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = addr; req_wdata = wd; req_be = be;
    k = 0;
    while (!req_ready && k < 1000) begin @(negedge clk); k++; end
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; lat_rsp = -1; lat_rdy = -1; rd = '0;
    while (lat_rdy < 0 && k < 2000) begin
      if (rsp_valid && lat_rsp < 0) begin lat_rsp = k - 1; rd = rsp_rdata; end
      if (req_ready) lat_rdy = k - 1;
      if (lat_rdy < 0) begin @(negedge clk); k++; end
    end
  endtask

  task automatic do_wr(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be,
                       input string req);
    logic [15:0] rd; int lr, ly, e;
    e = exp_wr() + exp_rc() + (last_was_rd ? exp_ta() : 0);
    op(1'b1, a, d, be, rd, lr, ly);
    chk(ly == e, req, "write ready latency", ly, e);
    shadow[int'(a)] = merge(srd(int'(a)), d, be);
    last_was_rd = 0;
  endtask

  task automatic do_rd(input logic [19:0] a, input logic [1:0] be, input string req);
    logic [15:0] rd, ex; int lr, ly;
    op(1'b0, a, 16'h0, be, rd, lr, ly);
    ex = mask(srd(int'(a)), be);
    chk(rd == ex, req, "read data", rd, ex);
    chk(lr == exp_rd(), "R2", "rsp latency", lr, exp_rd());
    chk(ly == exp_rd() + exp_rc(), "R5", "read ready latency", ly, exp_rd() + exp_rc());
    last_was_rd = 1;
  endtask

  bit finished = 0;

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7741);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n && (mem_bs_n == 2'b11), "R9", "strobes after reset",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n}, 5'h1f);
    chk(!mem_dq_oe && !rsp_valid, "R9", "bus/rsp after reset", {mem_dq_oe, rsp_valid}, 0);
    chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);

    // R1 power manager not active: nothing accepted
    pwr_active = 1'b0;
    req_valid = 1'b1; req_wr = 1'b1; req_addr = 20'h00055; req_wdata = 16'hDEAD; req_be = 2'b11;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!req_ready && mem_ce_n, "R1", "no accept while powered down",
          {req_ready, mem_ce_n}, 2'b01);
    end
    req_valid = 1'b0;
    pwr_active = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1", "ready with power active", req_ready, 1);

    // R2 R3 whole word
    do_wr(20'h00000, 16'h1234, 2'b11, "R3");
    do_rd(20'h00000, 2'b11, "R2");
    // R4 lanes
    do_wr(20'h00010, 16'hAAAA, 2'b11, "R4");
    do_wr(20'h00010, 16'h1177, 2'b01, "R4");
    do_wr(20'h00010, 16'h2288, 2'b10, "R4");
    do_rd(20'h00010, 2'b11, "R4");
    do_rd(20'h00010, 2'b01, "R4");
    do_rd(20'h00010, 2'b10, "R4");
    do_wr(20'h00010, 16'hFFFF, 2'b00, "R4");
    do_rd(20'h00010, 2'b11, "R4");
    do_rd(20'h00010, 2'b00, "R4");
    // R7 top address, R8 write right after read
    do_wr(20'hFFFFF, 16'hC3C3, 2'b11, "R8");
    do_rd(20'hFFFFF, 2'b11, "R7");
    do_wr(20'hFFFFF, 16'h3C00, 2'b10, "R8");
    do_rd(20'hFFFFF, 2'b11, "R7");

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [19:0] a;
      logic [1:0]  be;
      a  = {16'h0000, 1'b0, 3'($urandom_range(0, 7))};
      be = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) do_wr(a, 16'($urandom), be, "R3");
      else                           do_rd(a, be, "R2");
    end
    repeat (10) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule